// File: doc/BRIEF.md
# Prescaled Up/Down Charge Accumulator

This block is the digital core of a coulomb counter. An external modulator delivers charge quanta as single-cycle pulses on one of two inputs, one for charge flowing in and one for charge flowing out. A bidirectional prescaler divides these quanta by 8·M, where M is a power of two from 1 to 128 chosen by a 3-bit code. Each completed group steps a 16-bit accumulated-charge register up or down by one.

The accumulator starts at mid-scale. It saturates at both ends instead of wrapping, and a sticky flag records each saturation. A charge-complete event can preset it to full scale. A host may load either byte of it, but only while the block is shut down. Shutdown also discards incoming quanta and clears the partial count held in the prescaler. A new prescaler code is not applied part-way through a group. It is taken up only when the partial count is at zero or a group completes, so the partial count never lies outside the active range.

Top module: `chg_accum`

## Requirements
- R1: After reset, the accumulated value is 16'h7FFF, both flags are 0 and the active prescaler code is 7 (M = 128).
- R2: With prescaler code k (M = 2^k), every 8·2^k up quanta raise the accumulated value by exactly one. The partial count starts at zero.
- R3: A down quantum arriving while the partial count is zero lowers the accumulated value at once and reloads the partial count to 8·M−1. After that, each further 8·M down quanta lower the value by one more. An up quantum at 8·M−1 completes a group.
- R4: An up and a down quantum in the same cycle cancel: neither the accumulated value nor the partial count changes.
- R5: A step up at 16'hFFFF leaves the value at 16'hFFFF and sets the overflow flag. The flag stays set until reset.
- R6: A step down at 16'h0000 leaves the value at 16'h0000 and sets the underflow flag. The flag stays set until reset.
- R7: While shutdown is 1, quanta are ignored and the partial count is held at zero.
- R8: A host strobe for the high byte (bits 15:8) or the low byte (bits 7:0) loads the data byte only while shutdown is 1. With shutdown at 0 the strobe has no effect.
- R9: When charge-complete mode is enabled, a rising edge on the charge-complete input sets the value to 16'hFFFF. With the mode disabled, or with the input held high, there is no preset.
- R10: A changed prescaler code takes effect only when the partial count is zero or a group completes. A partial count already running keeps the old group length until that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qnt_up | input | 1 | Charge-in quantum pulse |
| qnt_dn | input | 1 | Charge-out quantum pulse |
| psc_code | input | 3 | Prescaler code k, M = 2^k |
| shutdown | input | 1 | Shutdown; blocks quanta and enables host loads |
| cc_enable | input | 1 | Charge-complete mode enable |
| cc_done | input | 1 | Charge-complete input; its rising edge presets full scale |
| host_wr_hi | input | 1 | Load strobe for bits 15:8 |
| host_wr_lo | input | 1 | Load strobe for bits 7:0 |
| host_wdata | input | 8 | Host data byte |
| acc_value | output | 16 | Accumulated charge |
| ovf_flag | output | 1 | Sticky saturation-at-full flag |
| udf_flag | output | 1 | Sticky saturation-at-zero flag |

## Verification
The hardest situation to reach is a code change while a partial count is in flight. The ports show no partial count, so the deferral can only be seen as a step arriving after the old group length rather than the new one. The stimulus first sets code 3 and feeds ten quanta. It then switches to code 0 and counts the further quanta needed before the first step, and again before the second step. Saturation at both ends is reached by host loads made in shutdown, which place the value one step from each limit.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int ACC_W      = 16;
  localparam int BYTE_W     = ACC_W / 2;
  localparam int CODE_W     = 3;
  localparam int BASE_SHIFT = 3;
  localparam int RES_W      = BASE_SHIFT + (1 << CODE_W) - 1;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [RES_W-1:0]  res_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam acc_t ACC_FULL = '1;
  localparam acc_t ACC_MID  = acc_t'((1 << (ACC_W - 1)) - 1);

  // Largest partial count for a code: 8*2^code - 1
  function automatic res_t residue_top(code_t c);
    int unsigned span;
    span = 32'd1 << (BASE_SHIFT + int'(c));
    return res_t'(span - 1);
  endfunction

  // Saturating one-step move of the accumulator
  function automatic acc_t acc_move(acc_t v, logic up, logic dn);
    if (up && v != ACC_FULL) return v + acc_t'(1);
    if (dn && v != '0)       return v - acc_t'(1);
    return v;
  endfunction
endpackage

// File: rtl/chg_prescaler.sv
module chg_prescaler
  import chg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  q_up,
  input  logic  q_dn,
  input  logic  sd,
  input  code_t code_req,
  output logic  step_up,
  output logic  step_dn,
  output res_t  res_o,
  output code_t code_o
);
  res_t  res_q;
  code_t code_q;
  logic  up_only, dn_only, at_top, at_zero, adopt;

  assign up_only = q_up & ~q_dn & ~sd;
  assign dn_only = q_dn & ~q_up & ~sd;
  assign at_top  = (res_q == residue_top(code_q));
  assign at_zero = (res_q == '0);
  assign step_up = up_only & at_top;
  assign step_dn = dn_only & at_zero;
  // a new code is taken only where the partial count is on a boundary
  assign adopt   = sd | at_zero | step_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      code_q <= '1;
    end else begin
      if (adopt) code_q <= code_req;
      if (sd || step_up)  res_q <= '0;
      else if (step_dn)   res_q <= residue_top(code_req);
      else if (up_only)   res_q <= res_q + res_t'(1);
      else if (dn_only)   res_q <= res_q - res_t'(1);
    end
  end

  assign res_o  = res_q;
  assign code_o = code_q;
endmodule

// File: rtl/chg_acc_reg.sv
module chg_acc_reg
  import chg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              sd,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cc_en,
  input  logic              cc_in,
  output acc_t              acc_o,
  output logic              ovf_o,
  output logic              udf_o,
  output logic              host_ld,
  output logic              cc_preset
);
  acc_t acc_q, acc_d;
  logic cc_prev, ovf_q, udf_q;
  logic sat_hi_hit, sat_lo_hit;

  assign host_ld    = sd & (wr_hi | wr_lo);
  assign cc_preset  = cc_en & cc_in & ~cc_prev;
  assign sat_hi_hit = step_up & (acc_q == ACC_FULL) & ~host_ld & ~cc_preset;
  assign sat_lo_hit = step_dn & (acc_q == '0) & ~host_ld & ~cc_preset;

  always_comb begin
    acc_d = acc_q;
    if (host_ld) begin
      if (wr_hi) acc_d[ACC_W-1:BYTE_W] = wdata;
      if (wr_lo) acc_d[BYTE_W-1:0]     = wdata;
    end else if (cc_preset) begin
      acc_d = ACC_FULL;
    end else begin
      acc_d = acc_move(acc_q, step_up, step_dn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_MID;
      cc_prev <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      cc_prev <= cc_in;
      ovf_q   <= ovf_q | sat_hi_hit;
      udf_q   <= udf_q | sat_lo_hit;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
  assign udf_o = udf_q;
endmodule

// File: rtl/chg_accum.sv
module chg_accum
  import chg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        qnt_up,
  input  logic        qnt_dn,
  input  logic [2:0]  psc_code,
  input  logic        shutdown,
  input  logic        cc_enable,
  input  logic        cc_done,
  input  logic        host_wr_hi,
  input  logic        host_wr_lo,
  input  logic [7:0]  host_wdata,
  output logic [15:0] acc_value,
  output logic        ovf_flag,
  output logic        udf_flag
);
  // named internal events for the checker
  logic  step_up, step_dn, host_ld, cc_preset;
  res_t  res_now;
  code_t code_now;

  chg_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .q_up(qnt_up), .q_dn(qnt_dn), .sd(shutdown),
    .code_req(psc_code), .step_up(step_up), .step_dn(step_dn),
    .res_o(res_now), .code_o(code_now)
  );

  chg_acc_reg u_acc (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .sd(shutdown), .wr_hi(host_wr_hi), .wr_lo(host_wr_lo), .wdata(host_wdata),
    .cc_en(cc_enable), .cc_in(cc_done), .acc_o(acc_value),
    .ovf_o(ovf_flag), .udf_o(udf_flag), .host_ld(host_ld), .cc_preset(cc_preset)
  );
endmodule

// File: rtl/chg_accum_chk.sv
module chg_accum_chk
  import chg_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  shutdown,
  input logic  step_up,
  input logic  step_dn,
  input logic  host_ld,
  input logic  cc_preset,
  input acc_t  acc_value,
  input logic  ovf_flag,
  input logic  udf_flag,
  input res_t  res_now,
  input code_t code_now
);
  // R7
  sd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!step_up && !step_dn));
  // R7
  sd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (res_now == '0));
  // R4
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && acc_value != ACC_FULL && !host_ld && !cc_preset)
      |=> (acc_value == $past(acc_value) + acc_t'(1)));
  // R5
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && acc_value == ACC_FULL && !host_ld && !cc_preset)
      |=> (acc_value == ACC_FULL && ovf_flag));
  // R6
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && acc_value == '0 && !host_ld && !cc_preset)
      |=> (acc_value == '0 && udf_flag));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag |=> udf_flag);
  // R8
  host_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !cc_preset && !step_up && !step_dn) |=> $stable(acc_value));
  // R9
  preset_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_preset && !host_ld) |=> (acc_value == ACC_FULL));
  // R10
  residue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_now <= residue_top(code_now));
endmodule

bind chg_accum chg_accum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .step_up(step_up),
  .step_dn(step_dn), .host_ld(host_ld), .cc_preset(cc_preset),
  .acc_value(acc_value), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
  .res_now(res_now), .code_now(code_now)
);

// File: tb/sim_chg_accum.sv
`timescale 1ns/1ps
module sim_chg_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qnt_up = 1'b0, qnt_dn = 1'b0;
  logic [2:0]  psc_code = 3'd7;
  logic        shutdown = 1'b0, cc_enable = 1'b0, cc_done = 1'b0;
  logic        host_wr_hi = 1'b0, host_wr_lo = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [15:0] acc_value;
  logic        ovf_flag, udf_flag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic [15:0] acc;
    logic        ovf;
    logic        udf;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #4 clk = ~clk;

  chg_accum u0 (
    .clk(clk), .rst_n(rst_n), .qnt_up(qnt_up), .qnt_dn(qnt_dn),
    .psc_code(psc_code), .shutdown(shutdown), .cc_enable(cc_enable),
    .cc_done(cc_done), .host_wr_hi(host_wr_hi), .host_wr_lo(host_wr_lo),
    .host_wdata(host_wdata), .acc_value(acc_value), .ovf_flag(ovf_flag),
    .udf_flag(udf_flag)
  );

  // monitor: compares queued expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (acc_value !== e.acc || ovf_flag !== e.ovf || udf_flag !== e.udf) begin
          fails++;
          $display("FAIL %s: got acc=%h ovf=%b udf=%b, expected acc=%h ovf=%b udf=%b",
                   e.tag, acc_value, ovf_flag, udf_flag, e.acc, e.ovf, e.udf);
        end
      end
    end
  end

  // driver-side expectation: queued now, compared at the next falling edge
  task automatic expect_state(input logic [15:0] a, input logic o, input logic u,
                              input string tag);
    exp_t e;
    #1;
    e.acc = a; e.ovf = o; e.udf = u; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic quanta(input logic up, input logic dn, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      qnt_up = up; qnt_dn = dn;
    end
    @(negedge clk);
    qnt_up = 1'b0; qnt_dn = 1'b0;
  endtask

  task automatic host_load(input logic hi, input logic lo,
                           input logic [7:0] d, input logic in_sd);
    @(negedge clk);
    shutdown = in_sd; host_wr_hi = hi; host_wr_lo = lo; host_wdata = d;
    @(negedge clk);
    host_wr_hi = 1'b0; host_wr_lo = 1'b0;
    shutdown = 1'b0;
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk);
    host_wr_hi = 1'b1; host_wdata = w[15:8];
    @(negedge clk);
    host_wr_hi = 1'b0; host_wr_lo = 1'b1; host_wdata = w[7:0];
    @(negedge clk);
    host_wr_lo = 1'b0;
    shutdown = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_state(16'h7FFF, 1'b0, 1'b0, "R1 reset value");

    // R2 default M=128: 1024 quanta per step
    quanta(1'b1, 1'b0, 1023);
    expect_state(16'h7FFF, 1'b0, 1'b0, "R1 default code 7 needs 1024 quanta");
    quanta(1'b1, 1'b0, 1);
    expect_state(16'h8000, 1'b0, 1'b0, "R2 step after 1024 quanta");

    // R2 code 0: 8 quanta per step
    psc_code = 3'd0;
    quanta(1'b1, 1'b0, 8);
    expect_state(16'h8001, 1'b0, 1'b0, "R2 code 0 step after 8");
    // R2 code 2: 32 quanta per step
    psc_code = 3'd2;
    quanta(1'b1, 1'b0, 31);
    expect_state(16'h8001, 1'b0, 1'b0, "R2 code 2 no step at 31");
    quanta(1'b1, 1'b0, 1);
    expect_state(16'h8002, 1'b0, 1'b0, "R2 code 2 step at 32");

    // R3 down path with code 0
    psc_code = 3'd0;
    quanta(1'b0, 1'b1, 1);
    expect_state(16'h8001, 1'b0, 1'b0, "R3 immediate borrow");
    quanta(1'b0, 1'b1, 7);
    expect_state(16'h8001, 1'b0, 1'b0, "R3 seven downs after borrow");
    quanta(1'b0, 1'b1, 1);
    expect_state(16'h8000, 1'b0, 1'b0, "R3 second borrow");
    quanta(1'b1, 1'b0, 1);
    expect_state(16'h8001, 1'b0, 1'b0, "R3 up at top completes group");

    // R4 cancel
    quanta(1'b1, 1'b1, 5);
    expect_state(16'h8001, 1'b0, 1'b0, "R4 simultaneous cancel");
    quanta(1'b1, 1'b0, 8);
    expect_state(16'h8002, 1'b0, 1'b0, "R4 partial count untouched");

    // R7 shutdown
    quanta(1'b1, 1'b0, 3);
    @(negedge clk);
    shutdown = 1'b1;
    quanta(1'b1, 1'b0, 20);
    @(negedge clk);
    shutdown = 1'b0;
    expect_state(16'h8002, 1'b0, 1'b0, "R7 quanta ignored in shutdown");
    quanta(1'b1, 1'b0, 7);
    expect_state(16'h8002, 1'b0, 1'b0, "R7 partial count cleared");
    quanta(1'b1, 1'b0, 1);
    expect_state(16'h8003, 1'b0, 1'b0, "R7 full group after shutdown");

    // R8 host loads
    host_load(1'b1, 1'b0, 8'h12, 1'b0);
    expect_state(16'h8003, 1'b0, 1'b0, "R8 load ignored when active");
    load_word(16'hFFFE);
    expect_state(16'hFFFE, 1'b0, 1'b0, "R8 load in shutdown");

    // R5 ceiling
    quanta(1'b1, 1'b0, 8);
    expect_state(16'hFFFF, 1'b0, 1'b0, "R5 reach full");
    quanta(1'b1, 1'b0, 8);
    expect_state(16'hFFFF, 1'b1, 1'b0, "R5 saturate at full");
    quanta(1'b0, 1'b1, 1);
    expect_state(16'hFFFE, 1'b1, 1'b0, "R5 overflow flag sticky");

    // R6 floor
    host_load(1'b1, 1'b1, 8'h00, 1'b1);
    host_load(1'b0, 1'b1, 8'h01, 1'b1);
    expect_state(16'h0001, 1'b1, 1'b0, "R8 both bytes loaded");
    quanta(1'b0, 1'b1, 1);
    expect_state(16'h0000, 1'b1, 1'b0, "R6 reach zero");
    quanta(1'b0, 1'b1, 8);
    expect_state(16'h0000, 1'b1, 1'b1, "R6 saturate at zero");

    // R9 charge complete
    @(negedge clk);
    cc_done = 1'b1;
    idle(2);
    cc_done = 1'b0;
    expect_state(16'h0000, 1'b1, 1'b1, "R9 ignored when disabled");
    cc_enable = 1'b1;
    @(negedge clk);
    cc_done = 1'b1;
    @(negedge clk);
    expect_state(16'hFFFF, 1'b1, 1'b1, "R9 preset on rising edge");
    load_word(16'h1234);
    idle(2);
    expect_state(16'h1234, 1'b1, 1'b1, "R9 no preset while held high");
    cc_done = 1'b0;
    cc_enable = 1'b0;

    // R10 deferred code change
    psc_code = 3'd3;
    idle(1);
    quanta(1'b1, 1'b0, 10);
    psc_code = 3'd0;
    quanta(1'b1, 1'b0, 50);
    expect_state(16'h1234, 1'b1, 1'b1, "R10 old length kept mid-group");
    quanta(1'b1, 1'b0, 4);
    expect_state(16'h1235, 1'b1, 1'b1, "R10 group of 64 completes");
    quanta(1'b1, 1'b0, 7);
    expect_state(16'h1235, 1'b1, 1'b1, "R10 new length not yet reached");
    quanta(1'b1, 1'b0, 1);
    expect_state(16'h1236, 1'b1, 1'b1, "R10 new length 8 applies");

    // R1 reset clears flags again
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    expect_state(16'h7FFF, 1'b0, 1'b0, "R1 reset clears sticky flags");

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule